// File: doc/BRIEF.md
# Zero-Crossing Timeout Detector

This block supervises the line voltage of a three-phase system by watching one crossing strobe per phase. Each strobe is a single-cycle pulse produced upstream whenever that phase's waveform crosses zero. When a phase produces no strobe for a programmable window, the block raises a sticky flag for that phase. Metering firmware uses the flag to spot a phase that has dropped out, so that frequency tracking can move to a phase that is still live.

The window is taken from a 16-bit timeout value, and each unit of that value is worth 384 clock cycles. Each phase has its own prescaler and down-counter, so the three windows run independently. A timeout value of zero turns detection off. The flags can be read in two ways. The plain view is always visible and has no side effects. A read-and-clear request captures the flags into a holding register and clears them in the same cycle. An active-low interrupt is asserted while any flag is set whose mask bit is also set.

Top module: `zx_timeout_monitor`

## Requirements
- R1: After reset, all phase flags read 0, the read-and-clear data reads 0, and `irq_n_o` is 1.
- R2: A phase is reloaded at a clock edge (by its strobe, or by a change of the timeout value). If that phase then receives no further strobe, its flag becomes 1 at exactly 384×N clock edges after the reload, where N is the nonzero timeout value. The flag is still 0 one edge earlier.
- R3: A crossing strobe on a phase reloads only that phase's window. A phase strobed more often than once per window never sets its flag.
- R4: The three phases time out independently. Bit i of every status vector belongs to phase i, for i from 0 to 2.
- R5: While the timeout value is 0, no flag is ever set.
- R6: Any change of the timeout value reloads the windows of all phases with the new value, as seen at the edge where the change is sampled.
- R7: A set flag stays set, even after strobes resume, until a read-and-clear request. Reading `status_o` has no effect on the flags.
- R8: `irq_n_o` is 0 exactly when some phase has both its flag and its `irq_mask_i` bit at 1.
- R9: A request on `rdclr_req_i` at a clock edge copies the flags into `rdclr_data_o` and clears them at that edge. A flag whose timeout falls on that same edge stays set. `rdclr_data_o` holds its value until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zx_strobe_i | input | 3 | Single-cycle crossing pulse, one bit per phase |
| timeout_val_i | input | 16 | Window length in units of 384 cycles; 0 disables detection |
| irq_mask_i | input | 3 | Per-phase interrupt enable |
| rdclr_req_i | input | 1 | Read-and-clear request |
| status_o | output | 3 | Plain view of the sticky timeout flags |
| rdclr_data_o | output | 3 | Flags captured by the last read-and-clear request |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bound checker tests four rules on every cycle. Flags never drop except through a read-and-clear request. No flag rises while the timeout value is zero. A low interrupt always has a masked-in flag behind it. Each read-and-clear request returns the flags that were visible just before it. What a property cannot hold cheaply is left to the bench's directed scenarios: the exact edge at which a silent phase times out after 384×N cycles, the way one phase's strobes leave the other phases untouched, and the way a change of timeout value restarts every window.

// File: rtl/zx_pkg.sv
package zx_pkg;

    localparam int unsigned ZX_PHASES_DEF   = 3;
    localparam int unsigned ZX_TMR_W_DEF    = 16;
    localparam int unsigned ZX_PRESCALE_DEF = 384;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } zx_tmr_state_e;

endpackage

// File: rtl/zx_cfg_watch.sv
module zx_cfg_watch #(
    parameter int unsigned TMR_W = zx_pkg::ZX_TMR_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] cfg_i,
    output logic             change_o
);

    typedef struct packed {
        logic [TMR_W-1:0] prev;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cfg_i;
        change_o  = (cfg_i != st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zx_phase_timer.sv
module zx_phase_timer #(
    parameter int unsigned TMR_W    = zx_pkg::ZX_TMR_W_DEF,
    parameter int unsigned PRESCALE = zx_pkg::ZX_PRESCALE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             expire_o
);
    import zx_pkg::*;

    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [TMR_W-1:0] CNT_ONE  = TMR_W'(1);

    typedef struct packed {
        zx_tmr_state_e    state;
        logic [PRE_W-1:0] pre;
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (reload_i) begin
            st_d.pre   = '0;
            st_d.cnt   = load_val_i;
            st_d.state = (load_val_i == '0) ? TMR_IDLE : TMR_RUN;
        end else if (st_q.state == TMR_RUN) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                if (st_q.cnt == CNT_ONE) begin
                    expire_o = 1'b1;
                    st_d.cnt = load_val_i;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: TMR_IDLE, pre: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zx_status_regs.sv
module zx_status_regs #(
    parameter int unsigned PHASES = zx_pkg::ZX_PHASES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] expire_i,
    input  logic              rdclr_i,
    input  logic [PHASES-1:0] mask_i,
    output logic [PHASES-1:0] flags_o,
    output logic [PHASES-1:0] rd_data_o,
    output logic              irq_n_o
);

    typedef struct packed {
        logic [PHASES-1:0] flags;
        logic [PHASES-1:0] rd_data;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rdclr_i) begin
            st_d.rd_data = st_q.flags;
            st_d.flags   = expire_i;
        end else begin
            st_d.flags   = st_q.flags | expire_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o   = st_q.flags;
    assign rd_data_o = st_q.rd_data;
    assign irq_n_o   = ~|(st_q.flags & mask_i);

endmodule

// File: rtl/zx_timeout_monitor.sv
module zx_timeout_monitor #(
    parameter int unsigned PHASES   = zx_pkg::ZX_PHASES_DEF,
    parameter int unsigned TMR_W    = zx_pkg::ZX_TMR_W_DEF,
    parameter int unsigned PRESCALE = zx_pkg::ZX_PRESCALE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] zx_strobe_i,
    input  logic [TMR_W-1:0]  timeout_val_i,
    input  logic [PHASES-1:0] irq_mask_i,
    input  logic              rdclr_req_i,
    output logic [PHASES-1:0] status_o,
    output logic [PHASES-1:0] rdclr_data_o,
    output logic              irq_n_o
);

    logic              cfg_change;
    logic [PHASES-1:0] expire;

    zx_cfg_watch #(.TMR_W(TMR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (timeout_val_i),
        .change_o (cfg_change)
    );

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        zx_phase_timer #(
            .TMR_W    (TMR_W),
            .PRESCALE (PRESCALE)
        ) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .reload_i   (zx_strobe_i[ph] | cfg_change),
            .load_val_i (timeout_val_i),
            .expire_o   (expire[ph])
        );
    end

    zx_status_regs #(.PHASES(PHASES)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .rdclr_i   (rdclr_req_i),
        .mask_i    (irq_mask_i),
        .flags_o   (status_o),
        .rd_data_o (rdclr_data_o),
        .irq_n_o   (irq_n_o)
    );

endmodule

// File: rtl/zx_timeout_monitor_sva.sv
module zx_timeout_monitor_sva #(
    parameter int unsigned PHASES = 3,
    parameter int unsigned TMR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TMR_W-1:0]  timeout_val_i,
    input logic [PHASES-1:0] irq_mask_i,
    input logic              rdclr_req_i,
    input logic [PHASES-1:0] status_o,
    input logic [PHASES-1:0] rdclr_data_o,
    input logic              irq_n_o
);

    // R7: flags only drop through a read-and-clear request
    assert_sticky_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdclr_req_i |=> (($past(status_o) & ~status_o) == '0));

    // R5: a zero timeout never raises a flag
    assert_zero_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_val_i == '0 && !rdclr_req_i) |=> (status_o == $past(status_o)));

    // R8: a low interrupt needs a masked-in flag
    assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> ((status_o & irq_mask_i) != '0));

    // R9: read-and-clear returns the flags seen before the request
    assert_rdclr_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdclr_req_i |=> (rdclr_data_o == $past(status_o)));

endmodule

bind zx_timeout_monitor zx_timeout_monitor_sva #(
    .PHASES (PHASES),
    .TMR_W  (TMR_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .timeout_val_i (timeout_val_i),
    .irq_mask_i    (irq_mask_i),
    .rdclr_req_i   (rdclr_req_i),
    .status_o      (status_o),
    .rdclr_data_o  (rdclr_data_o),
    .irq_n_o       (irq_n_o)
);

// File: tb/zx_timeout_monitor_test.sv
`timescale 1ns/1ps
module zx_timeout_monitor_test;

    localparam int UNIT = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  zx_strobe = '0;
    logic [15:0] timeout_val = '0;
    logic [2:0]  irq_mask = '0;
    logic        rdclr_req = 1'b0;
    logic [2:0]  status;
    logic [2:0]  rdclr_data;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    zx_timeout_monitor uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .zx_strobe_i   (zx_strobe),
        .timeout_val_i (timeout_val),
        .irq_mask_i    (irq_mask),
        .rdclr_req_i   (rdclr_req),
        .status_o      (status),
        .rdclr_data_o  (rdclr_data),
        .irq_n_o       (irq_n)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Disable, clear flags, then load v; returns one edge after the reload.
    task automatic arm(input logic [15:0] v);
        @(negedge clk);
        timeout_val = '0;
        rdclr_req = 1'b1;
        @(negedge clk);
        rdclr_req = 1'b0;
        timeout_val = v;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [2:0] which);
        zx_strobe = which;
        @(negedge clk);
        zx_strobe = '0;
    endtask

    task automatic rdclr_pulse();
        rdclr_req = 1'b1;
        @(negedge clk);
        rdclr_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status after reset", status, 3'b000);
        check("R1 rdclr data after reset", rdclr_data, 3'b000);
        check("R1 irq_n after reset", {2'b00, irq_n}, 3'b001);
    endtask

    task automatic t_basic_timeout();
        arm(16'd2);
        wait_n(2*UNIT - 1);
        check("R2 no flag one edge early", status, 3'b000);
        wait_n(1);
        check("R2 flags at 384*N", status, 3'b111);
        check("R8 masked out keeps irq high", {2'b00, irq_n}, 3'b001);
        rdclr_pulse();
        check("R9 rdclr returns flags", rdclr_data, 3'b111);
        check("R9 rdclr clears flags", status, 3'b000);
    endtask

    task automatic t_independent();
        arm(16'd2);
        wait_n(400);
        strobe(3'b010);
        wait_n(2*UNIT - 401);
        check("R4 other phases expire alone", status, 3'b101);
        wait_n(400);
        check("R3 strobed phase one edge early", status, 3'b101);
        wait_n(1);
        check("R3 strobed phase expires later", status, 3'b111);
    endtask

    task automatic t_periodic();
        arm(16'd1);
        for (int i = 0; i < 10; i++) begin
            wait_n(199);
            strobe(3'b100);
        end
        check("R3 periodic strobes hold phase 2 clear", status, 3'b011);
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 4; i++) begin
            strobe(3'b011);
            wait_n(5);
        end
        check("R7 flags stay after strobes resume", status, 3'b011);
        check("R7 plain read has no side effect", status, 3'b011);
        rdclr_pulse();
        check("R9 rdclr captures sticky flags", rdclr_data, 3'b011);
        check("R9 flags cleared", status, 3'b000);
        wait_n(10);
        check("R9 captured data holds", rdclr_data, 3'b011);
    endtask

    task automatic t_zero();
        arm(16'd0);
        wait_n(3000);
        check("R5 zero timeout sets nothing", status, 3'b000);
    endtask

    task automatic t_change();
        arm(16'd2);
        wait_n(500);
        timeout_val = 16'd3;
        @(negedge clk);
        wait_n(2*UNIT - 501);
        check("R6 old window no longer fires", status, 3'b000);
        wait_n(3*UNIT - (2*UNIT - 501) - 1);
        check("R6 new window one edge early", status, 3'b000);
        wait_n(1);
        check("R6 new window fires", status, 3'b111);
    endtask

    task automatic t_irq();
        irq_mask = 3'b000;
        @(negedge clk);
        check("R8 no mask irq high", {2'b00, irq_n}, 3'b001);
        irq_mask = 3'b010;
        @(negedge clk);
        check("R8 masked flag drives irq low", {2'b00, irq_n}, 3'b000);
        timeout_val = 16'd0;
        @(negedge clk);
        rdclr_pulse();
        check("R8 irq released after clear", {2'b00, irq_n}, 3'b001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_timeout();
        t_independent();
        t_periodic();
        t_sticky();
        t_zero();
        t_change();
        t_irq();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule